// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block is the home-node coherence directory for a shared-memory system with `N` write-back, write-allocate caches. Each memory line has one entry: a dirty flag and a presence vector with one bit per cache. An all-zero entry means the line is uncached. Caches send read misses, write misses, upgrades (a write to a clean copy they already hold) and replacements. The controller answers with data replies, grants without data, completion acknowledgements or nacks. When a line is dirty in another cache, it asks that cache for the line. When other caches share a line that is being written, it sends them invalidations and collects their acks.

A single transaction engine serialises the protocol. A request that needs no remote action completes in one cycle. A request that needs a fetch or invalidations occupies the engine until it finishes. While the engine is busy, every incoming request is nacked, so no line ever has more than one transaction in flight. Data payloads, the network and the memory array are outside the block. They appear only as handshake ports.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset no reply, nack, fetch or invalidation output is valid, and every line is uncached.
- R2: A read miss on an uncached or clean line gives a data reply (rsp_kind 0) with rsp_hops 1 in the next cycle. The line becomes clean and the requester is added to its sharers.
- R3: A read miss on a line dirty in cache k holds fwd_valid with fwd_dst k from the next cycle until fwd_done. The data reply follows one cycle after fwd_done, with rsp_hops 1 when k equals HOME and 2 otherwise. The line becomes clean, held by k and by the requester.
- R4: A write miss on a clean line shared by other caches pulses inv_valid for one cycle with inv_mask equal to those other sharers, excluding the requester. The reply comes one cycle after the ack that clears the last pending sharer, and the line becomes dirty, owned only by the requester.
- R5: A write miss on a line dirty in cache k fetches from k as in R3. The data reply follows one cycle after fwd_done, and the requester becomes the sole dirty owner.
- R6: An upgrade (req_op 2) from a cache holding a clean copy behaves as in R4 or R10, but the reply is a grant without data (rsp_kind 1). An upgrade from a cache without a copy is served as a write miss.
- R7: A replacement (req_op 3) gives a done reply (rsp_kind 2) in the next cycle. For a dirty owner the line becomes uncached. For a clean holder its bit is cleared, and the line becomes uncached when no holder remains. For a non-holder the entry is unchanged.
- R8: While a fetch or an invalidation round is in progress, any request is nacked in the next cycle (nack_err 0) and changes no directory state. The engine's own reply never comes early.
- R9: A read, write or upgrade from the cache that already owns the line dirty is nacked with nack_err 1, and the entry is unchanged.
- R10: A write miss or upgrade on a line with no sharers other than the requester completes in the next cycle without invalidations. The line becomes dirty, owned by the requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 upgrade, 3 replacement |
| req_src | input | $clog2(N) | Requesting cache |
| req_line | input | $clog2(LINES) | Line index |
| rsp_valid | output | 1 | Reply pulse |
| rsp_kind | output | 2 | 0 data, 1 grant without data, 2 replacement done |
| rsp_dst | output | $clog2(N) | Reply destination |
| rsp_line | output | $clog2(LINES) | Reply line |
| rsp_hops | output | 2 | 1 or 2 network hops for the data |
| nack_valid | output | 1 | Nack pulse |
| nack_dst | output | $clog2(N) | Nacked cache |
| nack_err | output | 1 | Nack caused by a protocol error |
| fwd_valid | output | 1 | Fetch request to the dirty owner, held until done |
| fwd_dst | output | $clog2(N) | Owner to fetch from |
| fwd_line | output | $clog2(LINES) | Line to fetch |
| fwd_done | input | 1 | Owner returned the line and memory is updated |
| inv_valid | output | 1 | Invalidation pulse |
| inv_mask | output | N | Caches to invalidate |
| inv_line | output | $clog2(LINES) | Line to invalidate |
| ack_valid | input | 1 | Invalidation ack present |
| ack_src | input | $clog2(N) | Cache sending the ack |

## Verification
Immediate replies, nacks, a new fetch request and an invalidation pulse all appear one cycle after the accepting edge. The reply of a fetched transaction appears one cycle after fwd_done. The reply of an invalidation round appears one cycle after the last pending ack. The bench drives on falling edges and reads each result on the falling edge that follows its due rising edge. In every waiting cycle it also checks that no reply has come early. A reference model of the directory in the bench predicts each reply kind, hop count, fetch target and invalidation mask, under both directed sequences and seeded random traffic with random ack delays and injected conflicting requests.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int N     = 4,
  parameter int LINES = 16,
  parameter int HOME  = 0,
  localparam int SW   = $clog2(N),
  localparam int LW   = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [SW-1:0] req_src,
  input  logic [LW-1:0] req_line,
  output logic          rsp_valid,
  output logic [1:0]    rsp_kind,
  output logic [SW-1:0] rsp_dst,
  output logic [LW-1:0] rsp_line,
  output logic [1:0]    rsp_hops,
  output logic          nack_valid,
  output logic [SW-1:0] nack_dst,
  output logic          nack_err,
  output logic          fwd_valid,
  output logic [SW-1:0] fwd_dst,
  output logic [LW-1:0] fwd_line,
  input  logic          fwd_done,
  output logic          inv_valid,
  output logic [N-1:0]  inv_mask,
  output logic [LW-1:0] inv_line,
  input  logic          ack_valid,
  input  logic [SW-1:0] ack_src
);
  localparam logic [1:0] OP_RD = 2'd0, OP_UPG = 2'd2, OP_EVT = 2'd3;
  localparam logic [1:0] K_DATA = 2'd0, K_GRANT = 2'd1, K_DONE = 2'd2;

  typedef enum logic [1:0] {IDLE, FETCH, INVW} state_t;
  state_t state;

  logic [N:0]    dir [LINES];
  logic [LW-1:0] t_line;
  logic [SW-1:0] t_src, t_owner;
  logic          t_wr, t_grant;
  logic [N-1:0]  pend;

  function automatic logic [SW-1:0] first_set(input logic [N-1:0] v);
    first_set = '0;
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) first_set = SW'(i);
  endfunction

  wire [N:0]   ent    = dir[req_line];
  wire         dirty  = ent[0];
  wire [N-1:0] pres   = ent[N:1];
  wire [N-1:0] sbit   = N'(1) << req_src;
  wire [N-1:0] tbit   = N'(1) << t_src;
  wire         own    = |(pres & sbit);
  wire [N-1:0] others = pres & ~sbit;
  wire [N-1:0] pend_n = pend & ~(N'(1) << ack_src);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE;
      for (int l = 0; l < LINES; l++) dir[l] <= '0;
      {rsp_valid, nack_valid, nack_err, fwd_valid, inv_valid} <= '0;
      {rsp_kind, rsp_dst, rsp_line, rsp_hops, nack_dst} <= '0;
      {fwd_dst, fwd_line, inv_mask, inv_line} <= '0;
      {t_line, t_src, t_owner, t_wr, t_grant, pend} <= '0;
    end else begin
      rsp_valid  <= 1'b0;
      nack_valid <= 1'b0;
      nack_err   <= 1'b0;
      inv_valid  <= 1'b0;
      if (req_valid) begin
        if (state != IDLE || (dirty && own && req_op != OP_EVT)) begin
          nack_valid <= 1'b1;
          nack_dst   <= req_src;
          nack_err   <= (state == IDLE);
        end else begin
          t_line  <= req_line;
          t_src   <= req_src;
          t_wr    <= (req_op != OP_RD);
          t_grant <= (req_op == OP_UPG) && own;
          rsp_dst <= req_src;
          rsp_line <= req_line;
          rsp_hops <= 2'd1;
          if (req_op == OP_EVT) begin
            rsp_valid <= 1'b1;
            rsp_kind  <= K_DONE;
            if (own) dir[req_line] <= (dirty || others == '0) ? '0 : {others, 1'b0};
          end else if (dirty) begin
            state     <= FETCH;
            t_owner   <= first_set(pres);
            fwd_valid <= 1'b1;
            fwd_dst   <= first_set(pres);
            fwd_line  <= req_line;
          end else if (req_op == OP_RD) begin
            rsp_valid <= 1'b1;
            rsp_kind  <= K_DATA;
            dir[req_line] <= {pres | sbit, 1'b0};
          end else if (others != '0) begin
            state     <= INVW;
            pend      <= others;
            inv_valid <= 1'b1;
            inv_mask  <= others;
            inv_line  <= req_line;
          end else begin
            rsp_valid <= 1'b1;
            rsp_kind  <= ((req_op == OP_UPG) && own) ? K_GRANT : K_DATA;
            dir[req_line] <= {sbit, 1'b1};
          end
        end
      end
      if (state == FETCH && fwd_done) begin
        state     <= IDLE;
        fwd_valid <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_kind  <= K_DATA;
        rsp_hops  <= (int'(t_owner) == HOME) ? 2'd1 : 2'd2;
        dir[t_line] <= t_wr ? {tbit, 1'b1} : {tbit | (N'(1) << t_owner), 1'b0};
      end
      if (state == INVW && ack_valid) begin
        pend <= pend_n;
        if (pend_n == '0) begin
          state     <= IDLE;
          rsp_valid <= 1'b1;
          rsp_kind  <= t_grant ? K_GRANT : K_DATA;
          rsp_hops  <= 2'd1;
          dir[t_line] <= {tbit, 1'b1};
        end
      end
    end
  end

  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && state != IDLE |=> nack_valid && !nack_err); // R8
  AST_INV_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> inv_mask != '0 && !inv_mask[t_src]); // R4
  AST_INV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !inv_valid); // R4
  AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_done |=> fwd_valid && $stable(fwd_dst) && $stable(fwd_line)); // R3
  AST_FWD_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> fwd_dst != t_src); // R9
  AST_ERR_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    nack_err |-> nack_valid && !rsp_valid); // R9
endmodule

// File: tb/tb_dir_home_ctrl.sv
`timescale 1ns/1ps
module tb_dir_home_ctrl;
  localparam int N = 4, LINES = 16, HOME = 0;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, fwd_done = 0, ack_valid = 0;
  logic [1:0] req_op = 0;
  logic [1:0] req_src = 0, ack_src = 0;
  logic [3:0] req_line = 0;
  logic rsp_valid, nack_valid, nack_err, fwd_valid, inv_valid;
  logic [1:0] rsp_kind, rsp_dst, rsp_hops, nack_dst, fwd_dst;
  logic [3:0] rsp_line, fwd_line, inv_line, inv_mask;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [N-1:0] m_pres [LINES];
  bit m_dirty [LINES];

  always #10 clk = ~clk;

  dir_home_ctrl #(.N(N), .LINES(LINES), .HOME(HOME)) dut (.*);

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic chk_rsp(input string r, input int kind, input int hops, input int dst, input int line);
    chk(rsp_valid == 1'b1, {r, " reply valid"}, int'(rsp_valid), 1);
    chk(rsp_kind == kind, {r, " reply kind"}, int'(rsp_kind), kind);
    chk(rsp_hops == hops, {r, " hops"}, int'(rsp_hops), hops);
    chk(rsp_dst == dst && rsp_line == line, {r, " reply target"}, int'({rsp_dst, rsp_line}), (dst << 4) | line);
  endtask

  task automatic busy_wait(input int cyc);
    for (int c = 0; c < cyc; c++) begin
      bit inj = ($urandom_range(0, 2) == 0);
      int s = $urandom_range(0, N - 1);
      if (inj) begin
        req_valid = 1; req_op = 2'($urandom_range(0, 3));
        req_src = 2'(s); req_line = 4'($urandom_range(0, LINES - 1));
      end
      @(negedge clk);
      req_valid = 0;
      chk(!rsp_valid, "R8 no early reply", int'(rsp_valid), 0);
      if (inj) chk(nack_valid && nack_dst == s && !nack_err, "R8 nack while busy",
                   int'({nack_valid, nack_err}), 2);
    end
  endtask

  function automatic int owner_of(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic txn(input int op, input int src, input int line);
    logic [N-1:0] sb = N'(1) << src;
    logic [N-1:0] pr = m_pres[line];
    bit own = |(pr & sb);
    bit dty = m_dirty[line];
    logic [N-1:0] oth = pr & ~sb;
    req_valid = 1; req_op = 2'(op); req_src = 2'(src); req_line = 4'(line);
    @(negedge clk);
    req_valid = 0;
    if (dty && own && op != 3) begin
      chk(nack_valid && nack_err && nack_dst == src, "R9 owner error nack", int'({nack_valid, nack_err}), 3);
      chk(!rsp_valid, "R9 no reply", int'(rsp_valid), 0);
    end else if (op == 3) begin
      chk_rsp("R7", 2, 1, src, line);
      if (own) begin
        if (dty) m_pres[line] = '0; else m_pres[line] = oth;
        m_dirty[line] = 0;
      end
    end else if (dty) begin
      int k = owner_of(pr);
      chk(fwd_valid && fwd_dst == k && fwd_line == line, op == 0 ? "R3 fetch" : "R5 fetch",
          int'({fwd_valid, fwd_dst}), 4 | k);
      busy_wait($urandom_range(0, 3));
      fwd_done = 1;
      @(negedge clk);
      fwd_done = 0;
      chk_rsp(op == 0 ? "R3" : "R5", 0, (k == HOME) ? 1 : 2, src, line);
      chk(!fwd_valid, "R3 fetch released", int'(fwd_valid), 0);
      if (op == 0) begin m_pres[line] = pr | sb; m_dirty[line] = 0; end
      else begin m_pres[line] = sb; m_dirty[line] = 1; end
    end else if (op == 0) begin
      chk_rsp("R2", 0, 1, src, line);
      m_pres[line] = pr | sb; m_dirty[line] = 0;
    end else if (oth != '0) begin
      int left = $countones(oth);
      chk(inv_valid && inv_mask == oth && inv_line == line, "R4 invalidation mask", int'(inv_mask), int'(oth));
      for (int b = 0; b < N; b++) begin
        if (oth[b]) begin
          busy_wait($urandom_range(0, 2));
          ack_valid = 1; ack_src = 2'(b);
          @(negedge clk);
          ack_valid = 0;
          left--;
          if (left > 0) chk(!rsp_valid, "R4 reply waits for acks", int'(rsp_valid), 0);
        end
      end
      chk_rsp((op == 2 && own) ? "R6" : "R4", (op == 2 && own) ? 1 : 0, 1, src, line);
      m_pres[line] = sb; m_dirty[line] = 1;
    end else begin
      chk(!inv_valid, "R10 no invalidation", int'(inv_valid), 0);
      chk_rsp((op == 2 && own) ? "R6" : "R10", (op == 2 && own) ? 1 : 0, 1, src, line);
      m_pres[line] = sb; m_dirty[line] = 1;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int l = 0; l < LINES; l++) begin m_pres[l] = '0; m_dirty[l] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({rsp_valid, nack_valid, fwd_valid, inv_valid} == 4'b0, "R1 reset outputs idle",
        int'({rsp_valid, nack_valid, fwd_valid, inv_valid}), 0);
    txn(0, 1, 0);
    txn(0, 2, 0);
    txn(2, 1, 0);
    txn(0, 3, 0);
    txn(1, 0, 0);
    txn(0, 2, 0);
    txn(1, 2, 0);
    txn(0, 2, 0);
    txn(3, 2, 0);
    txn(1, 3, 0);
    txn(3, 1, 0);
    txn(2, 1, 5);
    txn(0, 0, 6);
    txn(0, 1, 6);
    txn(3, 0, 6);
    txn(3, 1, 6);
    txn(1, 2, 6);
    for (int i = 0; i < 400; i++)
      txn($urandom_range(0, 3), $urandom_range(0, N - 1), $urandom_range(0, 3));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule